// File: doc/BRIEF.md
# Floating-Point Rounding Unit

This block takes a magnitude that has already been truncated to its final width and settles it to its rounded value under a 3-bit rounding-mode code. With the magnitude it receives the sign of the result, a round bit, a sticky bit, and a flag saying that the result came from an effective subtraction. Its outputs are the rounded magnitude, the final sign, an indication that the result is an exact zero, and an indication that the mode code is not one the rounder can apply. It is used at the tail of an adder, multiplier or conversion datapath, after normalisation. Exponent adjustment and status-flag generation stay in the surrounding logic.

Five of the modes are the usual IEEE-style choices: nearest-even, toward zero, toward negative infinity, toward positive infinity and nearest-away. The sixth rounds to odd: it forces the LSB to one when bits were lost and never increments, so that a later narrowing can still round correctly. The dynamic-mode code, and any other code that is not defined, is rejected with the invalid-mode output, and the truncated value passes through unchanged. All four results are registered, so they appear one clock after the inputs.

Top module: `fp_round_unit`

## Requirements
- R1: Mode code 3'b000 (nearest, ties to even) adds one to the magnitude exactly when the round bit is 1 and either the sticky bit or magnitude bit 0 is 1.
- R2: Mode code 3'b001 (toward zero) never changes the magnitude.
- R3: Mode code 3'b010 (toward negative infinity) adds one to the magnitude exactly when the sign is 1 (negative) and the round or sticky bit is 1.
- R4: Mode code 3'b011 (toward positive infinity) adds one to the magnitude exactly when the sign is 0 and the round or sticky bit is 1.
- R5: Mode code 3'b100 (nearest, ties away from zero) adds one to the magnitude exactly when the round bit is 1.
- R6: Mode code 3'b101 (round to odd) never adds one. When the round or sticky bit is 1 it sets magnitude bit 0 to 1 and keeps the upper bits. Otherwise it leaves the magnitude as it is.
- R7: Mode codes 3'b110 and 3'b111 raise bad_mode and return the input magnitude unchanged. All other codes hold bad_mode at 0.
- R8: The output sign equals the input sign, except in the case described in R9.
- R9: When the result is an exact zero and eff_sub is 1, the output sign is 1 only under mode 3'b010, and 0 under every other code.
- R10: An increment of an all-ones magnitude wraps to zero within WIDTH bits.
- R11: exact_zero is 1 exactly when the rounded magnitude is zero and both the round bit and the sticky bit are 0.
- R12: All outputs are registered with one cycle of latency. A synchronous active-high reset clears them to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mag_in | input | WIDTH | Truncated magnitude |
| sign_in | input | 1 | Sign of the unrounded result (1 = negative) |
| round_bit | input | 1 | First bit below the LSB |
| sticky_bit | input | 1 | OR of all the lower discarded bits |
| rmode | input | 3 | Rounding-mode code |
| eff_sub | input | 1 | Result came from an effective subtraction |
| mag_out | output | WIDTH | Rounded magnitude |
| sign_out | output | 1 | Final sign |
| exact_zero | output | 1 | Result is an exact zero |
| bad_mode | output | 1 | Mode code is not applicable |

## Verification
A wrong increment decision shows up as an off-by-one mag_out in the cycle after the offending inputs. A faulty zero or sign path shows up as a flipped sign_out or exact_zero in that same cycle. The block holds no state apart from the output register, so no error can persist: every fault is visible within one cycle of the input that triggers it, and only for that input. For that reason the bench sweeps every combination of a 4-bit magnitude, the sign, the round and sticky bits, all eight codes and eff_sub.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'b000,
    RM_TO_ZERO   = 3'b001,
    RM_DOWN      = 3'b010,
    RM_UP        = 3'b011,
    RM_NEAR_AWAY = 3'b100,
    RM_ODD       = 3'b101,
    RM_RSVD      = 3'b110,
    RM_DYNAMIC   = 3'b111
  } rmode_e;

  typedef struct packed {
    logic near_even;
    logic to_zero;
    logic down;
    logic up;
    logic near_away;
    logic odd;
    logic bad;
  } rmode_sel_t;

  localparam int unsigned SEL_BITS = $bits(rmode_sel_t);

endpackage

// File: rtl/fp_round_mode_dec.sv
module fp_round_mode_dec
  import fp_round_pkg::*;
(
  input  logic [2:0]  code,
  output rmode_sel_t  sel
);

  always_comb begin
    sel = '0;
    case (rmode_e'(code))
      RM_NEAR_EVEN: sel.near_even = 1'b1;
      RM_TO_ZERO:   sel.to_zero   = 1'b1;
      RM_DOWN:      sel.down      = 1'b1;
      RM_UP:        sel.up        = 1'b1;
      RM_NEAR_AWAY: sel.near_away = 1'b1;
      RM_ODD:       sel.odd       = 1'b1;
      default:      sel.bad       = 1'b1;
    endcase
  end

endmodule

// File: rtl/fp_round_decide.sv
module fp_round_decide
  import fp_round_pkg::*;
(
  input  rmode_sel_t sel,
  input  logic       lsb,
  input  logic       neg,
  input  logic       rbit,
  input  logic       sbit,
  output logic       inexact,
  output logic       bump,
  output logic       jam
);

  always_comb begin
    inexact = rbit | sbit;
    bump    = (sel.near_even & rbit & (sbit | lsb))
            | (sel.down      & inexact & neg)
            | (sel.up        & inexact & ~neg)
            | (sel.near_away & rbit);
    jam     = sel.odd & inexact;
  end

endmodule

// File: rtl/fp_round_sign_zero.sv
module fp_round_sign_zero #(
  parameter int unsigned WIDTH = 24
) (
  input  logic [WIDTH-1:0] mag,
  input  logic             inexact,
  input  logic             neg,
  input  logic             eff_sub,
  input  logic             mode_down,
  output logic             zero,
  output logic             sign
);

  always_comb begin
    zero = (mag == '0) && !inexact;
    if (zero && eff_sub) sign = mode_down;
    else                 sign = neg;
  end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_round_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] mag_in,
  input  logic             sign_in,
  input  logic             round_bit,
  input  logic             sticky_bit,
  input  logic [2:0]       rmode,
  input  logic             eff_sub,
  output logic [WIDTH-1:0] mag_out,
  output logic             sign_out,
  output logic             exact_zero,
  output logic             bad_mode
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  rmode_sel_t       sel;
  logic             inexact, bump, jam;
  logic [WIDTH-1:0] mag_rnd;
  logic             zero_c, sign_c;
  logic             primed_q;

  fp_round_mode_dec u_dec (
    .code (rmode),
    .sel  (sel)
  );

  fp_round_decide u_decide (
    .sel     (sel),
    .lsb     (mag_in[0]),
    .neg     (sign_in),
    .rbit    (round_bit),
    .sbit    (sticky_bit),
    .inexact (inexact),
    .bump    (bump),
    .jam     (jam)
  );

  always_comb begin
    if (sel.bad)   mag_rnd = mag_in;
    else if (jam)  mag_rnd = mag_in | ONE;
    else if (bump) mag_rnd = mag_in + ONE;
    else           mag_rnd = mag_in;
  end

  fp_round_sign_zero #(.WIDTH(WIDTH)) u_sz (
    .mag       (mag_rnd),
    .inexact   (inexact),
    .neg       (sign_in),
    .eff_sub   (eff_sub),
    .mode_down (sel.down),
    .zero      (zero_c),
    .sign      (sign_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_out    <= '0;
      sign_out   <= 1'b0;
      exact_zero <= 1'b0;
      bad_mode   <= 1'b0;
      primed_q   <= 1'b0;
    end else begin
      mag_out    <= mag_rnd;
      sign_out   <= sign_c;
      exact_zero <= zero_c;
      bad_mode   <= sel.bad;
      primed_q   <= 1'b1;
    end
  end

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);

  // R7
  bad_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    sel.bad |-> mag_rnd == mag_in);

  // R2
  tz_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    sel.to_zero |-> mag_rnd == mag_in);

  // R6
  odd_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (sel.odd && inexact) |-> (mag_rnd[0] && mag_rnd[WIDTH-1:1] == mag_in[WIDTH-1:1]));

  // R9
  zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_c && eff_sub && !sel.down) |-> !sign_c);

  // R11
  zero_mag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_c |-> (mag_rnd == '0 && !round_bit && !sticky_bit));

  // R12
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    primed_q |=> (mag_out == $past(mag_rnd) && bad_mode == $past(sel.bad)));

endmodule

// File: tb/fp_round_unit_tb.sv
module fp_round_unit_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] mag_in = '0;
  logic         sign_in = 1'b0, round_bit = 1'b0, sticky_bit = 1'b0, eff_sub = 1'b0;
  logic [2:0]   rmode = 3'b000;
  logic [W-1:0] mag_out;
  logic         sign_out, exact_zero, bad_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_round_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .mag_in(mag_in), .sign_in(sign_in),
    .round_bit(round_bit), .sticky_bit(sticky_bit), .rmode(rmode),
    .eff_sub(eff_sub), .mag_out(mag_out), .sign_out(sign_out),
    .exact_zero(exact_zero), .bad_mode(bad_mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d mag %0d s %0b r %0b st %0b sub %0b)",
               tag, act, exp, rmode, mag_in, sign_in, round_bit, sticky_bit, eff_sub);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 mag", int'(mag_out), 0);
    check("R12 sign", int'(sign_out), 0);
    check("R12 zero", int'(exact_zero), 0);
    check("R12 bad", int'(bad_mode), 0);
    rst = 1'b0;
    for (int v = 0; v < (1 << (W + 7)); v++) begin
      logic [W-1:0] m;
      logic sg, r, st, sub, inx, inc, bad, zr, es;
      logic [2:0] md;
      logic [W-1:0] em;
      string mtag;
      m   = v[W-1:0];
      sg  = v[W];
      r   = v[W+1];
      st  = v[W+2];
      sub = v[W+3];
      md  = v[W+6:W+4];
      mag_in = m; sign_in = sg; round_bit = r; sticky_bit = st; eff_sub = sub; rmode = md;
      inx = r | st;
      inc = 1'b0; bad = 1'b0;
      case (md)
        3'd0: begin inc = r & (st | m[0]); mtag = "R1"; end
        3'd1: begin mtag = "R2"; end
        3'd2: begin inc = inx & sg;  mtag = "R3"; end
        3'd3: begin inc = inx & ~sg; mtag = "R4"; end
        3'd4: begin inc = r; mtag = "R5"; end
        3'd5: begin mtag = "R6"; end
        default: begin bad = 1'b1; mtag = "R7"; end
      endcase
      if (md == 3'd5) em = inx ? (m | W'(1)) : m;
      else            em = m + W'(inc);
      if (inc && m == {W{1'b1}}) mtag = "R10";
      zr = (em == '0) && !inx;
      es = (zr && sub) ? (md == 3'd2) : sg;
      @(negedge clk);
      check(mtag, int'(mag_out), int'(em));
      check("R7 bad_mode", int'(bad_mode), int'(bad));
      check("R11 exact_zero", int'(exact_zero), int'(zr));
      check((zr && sub) ? "R9 sign" : "R8 sign", int'(sign_out), int'(es));
    end
    // R12 synchronous reset clears registered outputs
    mag_in = 4'd9; rmode = 3'd7; rst = 1'b1;
    @(negedge clk);
    check("R12 reset mag", int'(mag_out), 0);
    check("R12 reset bad", int'(bad_mode), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule